// File: doc/BRIEF.md
# Channel Interrupt Aggregator

This block folds interrupt events from a set of host channels into one interrupt line for the processor. Every channel owns a cause register and a cause mask. Each cause bit is set by a one-cycle event pulse, and software clears it by writing 1 to it. A channel summary vector has one bit per channel. Each bit is computed live from that channel's causes and cause mask, and the vector has its own channel mask. A channel-pending status bit reports that some summary bit is up. A global enable gates the final line.

Nothing above the cause level is stored. The only way to drop a summary bit or the pending status is to clear the causes underneath it. Status is recorded whatever the masks say; a mask only decides whether an event reaches the line. Software reaches the registers over a simple synchronous read/write bus. Read data is registered.

Address map (word addresses):

- 0x00: control, bit 0 = global enable.
- 0x01: pending status, bit 0.
- 0x02: summary vector, read-only.
- 0x03: channel mask.
- From 0x10, two words per channel: channel n's cause register at 0x10+2n and its cause mask at 0x11+2n.

Top module: `chan_irq_aggr`

## Requirements
- R1: After reset, every cause, cause mask, the channel mask and the global enable read as 0, and `irq_o` is low.
- R2: A pulse on `evt_i[n*NUM_CAUSE+c]` sets bit c of channel n's cause register (address 0x10+2n) on the next clock edge, whatever the masks hold.
- R3: Writing a word to a cause register clears each bit written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a write-1-to-clear hit the same cause bit in one cycle, the bit ends up set.
- R5: Summary bit n (address 0x02) is the OR of channel n's cause bits ANDed with its cause mask. Writes to 0x02 are ignored.
- R6: Pending status (address 0x01, bit 0) is the OR of all summary bits, independent of the channel mask. It falls only when the causes beneath it are cleared.
- R7: In every mask, 1 unmasks and 0 masks. `irq_o` equals the global enable AND the OR over channels of (summary bit AND channel mask bit).
- R8: The global enable (address 0x00, bit 0) gates only `irq_o`. Causes, summary and pending keep updating while it is 0.
- R9: Read data appears on `bus_rdata_o` in the cycle after the read request and holds until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_CH*NUM_CAUSE | One-cycle event pulses, channel-major |
| bus_en_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
A table of single events is swept across the first, a middle and the last channel. Each entry pairs a cause mask, a channel mask and an enable setting, so the stimulus tells apart a block at the cause level, at the channel level and at the global gate from a genuine interrupt.

For every entry the bench reads the cause, summary and pending registers. This shows that status is recorded even when the line stays low, and that only a cause clear brings it down.

Directed tests then cover:
- the reset state;
- mixed 1/0 clear words;
- a clear racing an event on the same bit;
- a write to the read-only summary;
- addresses past the last channel.

// File: rtl/cia_pkg.sv
package cia_pkg;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PEND  = 1;
    localparam int ADDR_SUMM  = 2;
    localparam int ADDR_SMASK = 3;
    localparam int CH_BASE    = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PEND,
        SEL_SUMM,
        SEL_SMASK,
        SEL_CAUSE,
        SEL_CMASK
    } reg_sel_e;

endpackage

// File: rtl/cia_addr_dec.sv
module cia_addr_dec
    import cia_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [CH_W-1:0]   ch_o
);

    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(ADDR_PEND);
    localparam logic [ADDR_W-1:0] A_SUMM  = ADDR_W'(ADDR_SUMM);
    localparam logic [ADDR_W-1:0] A_SMASK = ADDR_W'(ADDR_SMASK);
    localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] A_NCH   = ADDR_W'(NUM_CH);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        off   = addr_i - A_BASE;
        idx   = off >> 1;
        sel_o = SEL_NONE;
        ch_o  = idx[CH_W-1:0];
        if (addr_i == A_CTRL) begin
            sel_o = SEL_CTRL;
        end else if (addr_i == A_PEND) begin
            sel_o = SEL_PEND;
        end else if (addr_i == A_SUMM) begin
            sel_o = SEL_SUMM;
        end else if (addr_i == A_SMASK) begin
            sel_o = SEL_SMASK;
        end else if ((addr_i >= A_BASE) && (idx < A_NCH)) begin
            sel_o = off[0] ? SEL_CMASK : SEL_CAUSE;
        end
    end

endmodule

// File: rtl/cia_chan_regs.sv
module cia_chan_regs #(
    parameter int NUM_CAUSE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CAUSE-1:0] evt_i,
    input  logic                 wr_cause_i,
    input  logic                 wr_mask_i,
    input  logic [NUM_CAUSE-1:0] wdata_i,
    output logic [NUM_CAUSE-1:0] cause_o,
    output logic [NUM_CAUSE-1:0] mask_o,
    output logic                 pend_o
);

    typedef struct packed {
        logic [NUM_CAUSE-1:0] cause;
        logic [NUM_CAUSE-1:0] mask;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask_i) begin
            st_d.mask = wdata_i;
        end
        if (wr_cause_i) begin
            st_d.cause = st_q.cause & ~wdata_i;
        end
        // a new event wins over a clear of the same bit
        st_d.cause = st_d.cause | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign pend_o  = |(st_q.cause & st_q.mask);

endmodule

// File: rtl/cia_glob_regs.sv
module cia_glob_regs #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_smask_i,
    input  logic              ctrl_bit_i,
    input  logic [NUM_CH-1:0] smask_wdata_i,
    input  logic [NUM_CH-1:0] summary_i,
    output logic              gen_o,
    output logic [NUM_CH-1:0] smask_o,
    output logic              pending_o,
    output logic              irq_o
);

    typedef struct packed {
        logic              gen;
        logic [NUM_CH-1:0] smask;
    } glob_st_t;

    glob_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl_i) begin
            st_d.gen = ctrl_bit_i;
        end
        if (wr_smask_i) begin
            st_d.smask = smask_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gen_o     = st_q.gen;
    assign smask_o   = st_q.smask;
    assign pending_o = |summary_i;
    assign irq_o     = st_q.gen & (|(summary_i & st_q.smask));

endmodule

// File: rtl/cia_read_mux.sv
module cia_read_mux
    import cia_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_CAUSE = 8,
    parameter int DATA_W    = 16,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en_i,
    input  reg_sel_e                    sel_i,
    input  logic [CH_W-1:0]             ch_i,
    input  logic                        gen_i,
    input  logic                        pending_i,
    input  logic [NUM_CH-1:0]           summary_i,
    input  logic [NUM_CH-1:0]           smask_i,
    input  logic [NUM_CH*NUM_CAUSE-1:0] cause_flat_i,
    input  logic [NUM_CH*NUM_CAUSE-1:0] cmask_flat_i,
    output logic [DATA_W-1:0]           rdata_o
);

    logic [NUM_CAUSE-1:0] cause_arr [NUM_CH];
    logic [NUM_CAUSE-1:0] cmask_arr [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
        assign cause_arr[i] = cause_flat_i[i*NUM_CAUSE +: NUM_CAUSE];
        assign cmask_arr[i] = cmask_flat_i[i*NUM_CAUSE +: NUM_CAUSE];
    end

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en_i) begin
            rdata_d = '0;
            case (sel_i)
                SEL_CTRL:  rdata_d[0]           = gen_i;
                SEL_PEND:  rdata_d[0]           = pending_i;
                SEL_SUMM:  rdata_d[NUM_CH-1:0]  = summary_i;
                SEL_SMASK: rdata_d[NUM_CH-1:0]  = smask_i;
                SEL_CAUSE: rdata_d[NUM_CAUSE-1:0] = cause_arr[ch_i];
                SEL_CMASK: rdata_d[NUM_CAUSE-1:0] = cmask_arr[ch_i];
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/chan_irq_aggr.sv
module chan_irq_aggr
    import cia_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_CAUSE = 8,
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH*NUM_CAUSE-1:0] evt_i,
    input  logic                        bus_en_i,
    input  logic                        bus_we_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [DATA_W-1:0]           bus_wdata_i,
    output logic [DATA_W-1:0]           bus_rdata_o,
    output logic                        irq_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_sel_e  sel;
    logic [CH_W-1:0] ch_sel;
    logic      wr_en;
    logic      rd_en;

    logic [NUM_CH*NUM_CAUSE-1:0] cause_flat;
    logic [NUM_CH*NUM_CAUSE-1:0] cmask_flat;
    logic [NUM_CH-1:0]           summary;
    logic [NUM_CH-1:0]           smask;
    logic                        gen_en;
    logic                        pending;

    assign wr_en = bus_en_i & bus_we_i;
    assign rd_en = bus_en_i & ~bus_we_i;

    cia_addr_dec #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel),
        .ch_o   (ch_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (ch_sel == CH_W'(i));

        cia_chan_regs #(
            .NUM_CAUSE (NUM_CAUSE)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_i[i*NUM_CAUSE +: NUM_CAUSE]),
            .wr_cause_i (hit && (sel == SEL_CAUSE)),
            .wr_mask_i  (hit && (sel == SEL_CMASK)),
            .wdata_i    (bus_wdata_i[NUM_CAUSE-1:0]),
            .cause_o    (cause_flat[i*NUM_CAUSE +: NUM_CAUSE]),
            .mask_o     (cmask_flat[i*NUM_CAUSE +: NUM_CAUSE]),
            .pend_o     (summary[i])
        );
    end

    cia_glob_regs #(
        .NUM_CH (NUM_CH)
    ) u_glob (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_ctrl_i     (wr_en && (sel == SEL_CTRL)),
        .wr_smask_i    (wr_en && (sel == SEL_SMASK)),
        .ctrl_bit_i    (bus_wdata_i[0]),
        .smask_wdata_i (bus_wdata_i[NUM_CH-1:0]),
        .summary_i     (summary),
        .gen_o         (gen_en),
        .smask_o       (smask),
        .pending_o     (pending),
        .irq_o         (irq_o)
    );

    cia_read_mux #(
        .NUM_CH    (NUM_CH),
        .NUM_CAUSE (NUM_CAUSE),
        .DATA_W    (DATA_W)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en_i      (rd_en),
        .sel_i        (sel),
        .ch_i         (ch_sel),
        .gen_i        (gen_en),
        .pending_i    (pending),
        .summary_i    (summary),
        .smask_i      (smask),
        .cause_flat_i (cause_flat),
        .cmask_flat_i (cmask_flat),
        .rdata_o      (bus_rdata_o)
    );

endmodule

// File: rtl/cia_checker.sv
module cia_checker #(
    parameter int NUM_CH    = 16,
    parameter int NUM_CAUSE = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_CH*NUM_CAUSE-1:0] evt_i,
    input logic                        bus_en_i,
    input logic                        bus_we_i,
    input logic                        irq_o,
    input logic                        gen_en,
    input logic [NUM_CH-1:0]           smask,
    input logic [NUM_CH*NUM_CAUSE-1:0] cause_flat
);

    // R2: every pulsed cause bit is set one edge later
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((cause_flat & $past(evt_i)) == $past(evt_i)));

    // R3: a cause bit can only fall across a bus write
    a_r3_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en_i && bus_we_i) |=> ((~cause_flat & $past(cause_flat)) == '0));

    // R7: with no cause pending the line is low
    a_r7_no_cause_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_flat == '0) |-> !irq_o);

    // R7: an all-zero channel mask blocks the line
    a_r7_smask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (smask == '0) |-> !irq_o);

    // R8: the line needs the global enable
    a_r8_gen_gates: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gen_en);

endmodule

bind chan_irq_aggr cia_checker #(
    .NUM_CH    (NUM_CH),
    .NUM_CAUSE (NUM_CAUSE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .bus_en_i   (bus_en_i),
    .bus_we_i   (bus_we_i),
    .irq_o      (irq_o),
    .gen_en     (gen_en),
    .smask      (smask),
    .cause_flat (cause_flat)
);

// File: tb/chan_irq_aggr_bench.sv
module chan_irq_aggr_bench;

    localparam int NCH = 16;
    localparam int NCA = 8;
    localparam int AW  = 6;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*NCA-1:0] evt = '0;
    logic              en = 1'b0;
    logic              we = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chan_irq_aggr #(
        .NUM_CH(NCH), .NUM_CAUSE(NCA), .ADDR_W(AW), .DATA_W(DW)
    ) u_chan_irq_aggr (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_en_i(en), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0]  ch;
        logic [2:0]  ca;
        logic [7:0]  cm;
        logic [15:0] sm;
        logic        ge;
        logic        irq;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'd0,  3'd0, 8'h01, 16'h0001, 1'b1, 1'b1},
        '{4'd5,  3'd3, 8'h08, 16'h0020, 1'b1, 1'b1},
        '{4'd5,  3'd3, 8'hF7, 16'h0020, 1'b1, 1'b0},
        '{4'd15, 3'd7, 8'h80, 16'h7FFF, 1'b1, 1'b0},
        '{4'd15, 3'd7, 8'h80, 16'h8000, 1'b0, 1'b0},
        '{4'd15, 3'd7, 8'h80, 16'h8000, 1'b1, 1'b1},
        '{4'd9,  3'd2, 8'hFF, 16'hFFFF, 1'b1, 1'b1},
        '{4'd3,  3'd6, 8'h40, 16'h0000, 1'b1, 1'b0}
    };

    function automatic logic [AW-1:0] cause_a(int ch);
        return AW'(16 + 2 * ch);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        en = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        en = 1'b0; we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        en = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(int idx);
        @(negedge clk);
        evt[idx] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic          hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq), 0);
        rd(8'h00 % 64, d); chk("R1 ctrl", 32'(d), 0);
        rd(6'h03, d); chk("R1 smask", 32'(d), 0);
        rd(cause_a(7), d); chk("R1 cause", 32'(d), 0);
        rd(cause_a(7) + 1, d); chk("R1 cmask", 32'(d), 0);
        // R9: read data holds with no request
        repeat (2) @(negedge clk);
        chk("R9 hold", 32'(rdata), 0);

        // table sweep: R2, R5, R6, R7, R8
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            logic bit_on;
            v = VEC[i];
            bit_on = v.cm[v.ca];
            wr(cause_a(v.ch) + 1, DW'(v.cm));
            wr(6'h03, v.sm);
            wr(6'h00, DW'(v.ge));
            pulse(int'(v.ch) * NCA + int'(v.ca));
            chk("R7 irq", 32'(irq), 32'(v.irq));
            rd(cause_a(v.ch), d); chk("R2 cause set", 32'(d), 32'(1) << v.ca);
            rd(6'h02, d); chk("R5 summary", 32'(d), 32'(bit_on) << v.ch);
            rd(6'h01, d); chk("R6 pending", 32'(d), 32'(bit_on));
            // R6: the channel mask does not clear pending
            wr(6'h03, 16'h0000);
            rd(6'h01, d); chk("R6 pending kept", 32'(d), 32'(bit_on));
            chk("R7 irq masked", 32'(irq), 0);
            wr(6'h03, v.sm);
            wr(cause_a(v.ch), 16'hFFFF);
            chk("R3 irq after clear", 32'(irq), 0);
            rd(6'h01, d); chk("R6 pending cleared", 32'(d), 0);
        end

        // R8: status records with enable off
        wr(6'h00, 16'h0000);
        wr(cause_a(2) + 1, 16'h00FF);
        wr(6'h03, 16'hFFFF);
        pulse(2 * NCA + 0);
        pulse(2 * NCA + 1);
        chk("R8 irq gated", 32'(irq), 0);
        rd(6'h01, d); chk("R8 pending while gated", 32'(d), 1);
        wr(6'h00, 16'h0001);
        chk("R8 irq after enable", 32'(irq), 1);

        // R3: zeros in the clear word keep bits
        wr(cause_a(2), 16'h0000);
        rd(cause_a(2), d); chk("R3 write 0", 32'(d), 32'h3);
        wr(cause_a(2), 16'h0001);
        rd(cause_a(2), d); chk("R3 write 1", 32'(d), 32'h2);

        // R5: summary is read-only
        rd(6'h02, d); hold = d[2];
        wr(6'h02, 16'h0000);
        rd(6'h02, d); chk("R5 write ignored", 32'(d[2]), 32'(hold));

        // R4: event and clear on the same bit in one cycle
        @(negedge clk);
        evt[2 * NCA + 1] = 1'b1;
        en = 1'b1; we = 1'b1; addr = cause_a(2); wdata = 16'h0002;
        @(negedge clk);
        evt = '0; en = 1'b0; we = 1'b0;
        rd(cause_a(2), d); chk("R4 event wins", 32'(d), 32'h2);
        wr(cause_a(2), 16'h00FF);
        chk("R7 irq off after clear", 32'(irq), 0);

        // R9: unmapped addresses
        rd(cause_a(NCH), d); chk("R9 past last channel", 32'(d), 0);
        rd(6'h3F, d); chk("R9 top address", 32'(d), 0);
        rd(6'h07, d); chk("R9 gap address", 32'(d), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule